// File: doc/BRIEF.md
# Dual-Slope Integrating Converter Controller

This block holds the timing and counting logic of a dual-slope analog-to-digital converter. A one-cycle `start` request, taken only while the block is idle, first discharges the external integrator for a parameterized number of cycles. The block then closes the input switch so the integrator charges from the unknown input for a fixed window of T1 = 2^N clock cycles. Next it switches the integrator to the negative reference and counts clocks until the comparator reports that the integrator output is no longer above zero. That count, T2, is the conversion code. The input voltage follows from Vin = Vref * T2 / T1, and because T1 is 2^N the count is the N-bit code itself.

The integrator, the analog switches and the comparator are outside the block. The comparator input `cmp_pos` is taken to be synchronous to `clk`. The controller is a five-state machine:

- IDLE: waits for `start`.
- DISCHARGE: holds `int_rst` high.
- INTEGRATE: holds `sel_in` high.
- DEINTEGRATE: holds `sel_ref` high and counts.
- DONE: a one-cycle completion state.

The transitions are:

- start-accept: IDLE to DISCHARGE.
- discharge-expired: DISCHARGE to INTEGRATE, after RST_CYC cycles.
- window-expired: INTEGRATE to DEINTEGRATE, after 2^N cycles.
- zero-cross or saturate: DEINTEGRATE to DONE.
- retire: DONE to IDLE.

If the count reaches 2^N - 1 while the comparator still reads high, the result saturates at full scale and the overrange flag is set.

Top module: `dsc_ctrl`

## Requirements
- R1: After reset, `int_rst`, `sel_in`, `sel_ref`, `busy`, `done` and `overrange` are 0 and `result` is 0.
- R2: A `start` seen high at a clock edge in IDLE makes `int_rst` and `busy` high from the next cycle, with `int_rst` high for exactly RST_CYC consecutive cycles.
- R3: Directly after the discharge phase, `sel_in` is high for exactly 2^N consecutive cycles.
- R4: Directly after the integrate phase, `sel_ref` is high. `sel_in` and `sel_ref` are never high in the same cycle.
- R5: In the deintegrate phase the count starts at 0 in its first cycle and rises by one per cycle. The first cycle in which `cmp_pos` is sampled low ends the phase, and its count becomes `result`, with `overrange` = 0.
- R6: If `cmp_pos` is still high in the deintegrate cycle whose count is 2^N - 1, the phase ends, `result` becomes all ones and `overrange` becomes 1.
- R7: When `cmp_pos` first reads low exactly in the cycle whose count is 2^N - 1, `result` is all ones with `overrange` = 0, because the zero crossing takes priority over saturation.
- R8: `done` is high for exactly one cycle, in the cycle right after the last deintegrate cycle, with `busy` low. The block then returns to IDLE with `busy` and `done` both low.
- R9: `start` has no effect while `busy` or `done` is high. The running conversion keeps its timing and no second conversion follows.
- R10: `result` and `overrange` change only at the edge that enters DONE, and hold their values until the next conversion completes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Conversion request, taken in IDLE only |
| cmp_pos | input | 1 | Comparator: 1 while the integrator output is above zero |
| int_rst | output | 1 | Integrator discharge switch |
| sel_in | output | 1 | Connect the unknown input to the integrator |
| sel_ref | output | 1 | Connect the negative reference to the integrator |
| busy | output | 1 | Conversion in progress (discharge, integrate, deintegrate) |
| done | output | 1 | One-cycle completion pulse |
| result | output | N | Conversion code T2 |
| overrange | output | 1 | Saturated result flag |

## Verification
Take P as the cycle in which `start` is sampled. The DISCHARGE state is visible one cycle after P, and `done` appears 1 + RST_CYC + 2^N + D cycles after P. D is the number of deintegrate cycles: the code plus one, or 2^N on saturation. The bench's driver computes this latency, the code, the overrange flag and the expected number of cycles for each select, and pushes them into a queue. Its monitor samples on the falling edge and counts select cycles from the start. It pops and compares an entry only in the cycle where `done` is seen, so every value is checked in the exact cycle the requirements set. A behavioural integrator turns a chosen code into comparator timing, which covers zero, mid-scale, exact full scale and overrange inputs.

// File: rtl/dsc_pkg.sv
package dsc_pkg;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_DISCH  = 3'd1,
        ST_INTEG  = 3'd2,
        ST_DEINT  = 3'd3,
        ST_DONE   = 3'd4
    } dsc_state_t;

    function automatic int unsigned dsc_max(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/dsc_timer.sv
module dsc_timer #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          en,
    output logic [CW-1:0] cnt
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clr) begin
            cnt <= '0;
        end else if (en) begin
            cnt <= cnt + 1'b1;
        end
    end

    // R5: the phase counter is cleared at every state change, so entering
    // deintegration starts counting from zero
    p_clear_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (cnt == '0));

endmodule

// File: rtl/dsc_result.sv
module dsc_result #(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cap,
    input  logic [N-1:0] cap_code,
    input  logic         cap_ovr,
    input  logic         done,
    output logic [N-1:0] result,
    output logic         overrange
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            result    <= '0;
            overrange <= 1'b0;
        end else if (cap) begin
            result    <= cap_code;
            overrange <= cap_ovr;
        end
    end

    // R6: a saturated conversion always reports full scale
    p_ovr_full_r6: assert property (@(posedge clk) disable iff (!rst_n)
        overrange |-> (result == '1));

    // R10: result only moves on the edge that enters the completion state
    p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(result) || !$stable(overrange)) |-> done);

endmodule

// File: rtl/dsc_fsm.sv
module dsc_fsm
    import dsc_pkg::*;
#(
    parameter int N       = 8,
    parameter int RST_CYC = 4,
    parameter int CW      = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          cmp_pos,
    input  logic [CW-1:0] tcnt,
    output logic          tclr,
    output logic          ten,
    output logic          cap,
    output logic [N-1:0]  cap_code,
    output logic          cap_ovr,
    output logic          int_rst,
    output logic          sel_in,
    output logic          sel_ref,
    output logic          busy,
    output logic          done
);

    localparam logic [CW-1:0] DISCH_LAST = CW'(RST_CYC - 1);
    localparam logic [CW-1:0] WIN_LAST   = CW'((1 << N) - 1);
    localparam logic [CW-1:0] FULL_CNT   = CW'((1 << N) - 1);

    dsc_state_t state_q, state_nx;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_nx;
        end
    end

    // transitions
    always_comb begin
        state_nx = state_q;
        cap      = 1'b0;
        cap_ovr  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (start) state_nx = ST_DISCH;          // start-accept
            end
            ST_DISCH: begin
                if (tcnt == DISCH_LAST) state_nx = ST_INTEG;   // discharge-expired
            end
            ST_INTEG: begin
                if (tcnt == WIN_LAST) state_nx = ST_DEINT;     // window-expired
            end
            ST_DEINT: begin
                if (!cmp_pos) begin                       // zero-cross
                    state_nx = ST_DONE;
                    cap      = 1'b1;
                end else if (tcnt == FULL_CNT) begin      // saturate
                    state_nx = ST_DONE;
                    cap      = 1'b1;
                    cap_ovr  = 1'b1;
                end
            end
            ST_DONE: begin
                state_nx = ST_IDLE;                       // retire
            end
            default: begin
                state_nx = ST_IDLE;
            end
        endcase
    end

    assign cap_code = tcnt[N-1:0];
    assign tclr     = (state_nx != state_q);
    assign ten      = !tclr;

    // outputs
    always_comb begin
        int_rst = 1'b0;
        sel_in  = 1'b0;
        sel_ref = 1'b0;
        busy    = 1'b0;
        done    = 1'b0;
        unique case (state_q)
            ST_IDLE:  ;
            ST_DISCH: begin int_rst = 1'b1; busy = 1'b1; end
            ST_INTEG: begin sel_in  = 1'b1; busy = 1'b1; end
            ST_DEINT: begin sel_ref = 1'b1; busy = 1'b1; end
            ST_DONE:  done = 1'b1;
            default:  ;
        endcase
    end

    // R4: the two integrator sources are never connected together
    p_sel_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(sel_in && sel_ref));

    // R3: integration always begins straight after discharge
    p_integ_after_disch_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sel_in) |-> $past(int_rst));

    // R4: the reference follows the input window directly
    p_ref_after_integ_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sel_in) |-> sel_ref);

    // R5: the deintegration count starts at zero
    p_ref_starts_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sel_ref) |-> (tcnt == '0));

    // R8: done is a single-cycle pulse followed by idle
    p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !busy));

    // R9: start is not taken while a conversion runs
    p_no_restart_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> (busy || done));

endmodule

// File: rtl/dsc_ctrl.sv
module dsc_ctrl
    import dsc_pkg::*;
#(
    parameter int N       = 8,
    parameter int RST_CYC = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic         cmp_pos,
    output logic         int_rst,
    output logic         sel_in,
    output logic         sel_ref,
    output logic         busy,
    output logic         done,
    output logic [N-1:0] result,
    output logic         overrange
);

    localparam int RBW = $clog2(RST_CYC + 1);
    localparam int CW  = int'(dsc_max(N, RBW));

    logic [CW-1:0] tcnt;
    logic          tclr;
    logic          ten;
    logic          cap;
    logic [N-1:0]  cap_code;
    logic          cap_ovr;

    dsc_timer #(.CW(CW)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (tclr),
        .en    (ten),
        .cnt   (tcnt)
    );

    dsc_fsm #(.N(N), .RST_CYC(RST_CYC), .CW(CW)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .cmp_pos  (cmp_pos),
        .tcnt     (tcnt),
        .tclr     (tclr),
        .ten      (ten),
        .cap      (cap),
        .cap_code (cap_code),
        .cap_ovr  (cap_ovr),
        .int_rst  (int_rst),
        .sel_in   (sel_in),
        .sel_ref  (sel_ref),
        .busy     (busy),
        .done     (done)
    );

    dsc_result #(.N(N)) u_result (
        .clk       (clk),
        .rst_n     (rst_n),
        .cap       (cap),
        .cap_code  (cap_code),
        .cap_ovr   (cap_ovr),
        .done      (done),
        .result    (result),
        .overrange (overrange)
    );

endmodule

// File: tb/dsc_ctrl_tb_top.sv
module dsc_ctrl_tb_top;

    localparam int N       = 8;
    localparam int RST_CYC = 4;
    localparam int T1      = 1 << N;
    localparam int FULL    = T1 - 1;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic         cmp_pos;
    logic         int_rst, sel_in, sel_ref, busy, done, overrange;
    logic [N-1:0] result;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int start_cyc = 0;
    int vin_code = 0;
    int acc = 0;

    typedef struct {
        int code;
        bit ovr;
        int lat;
        int nref;
    } exp_t;

    exp_t sbq[$];

    always #10 clk = ~clk;

    dsc_ctrl #(.N(N), .RST_CYC(RST_CYC)) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .cmp_pos   (cmp_pos),
        .int_rst   (int_rst),
        .sel_in    (sel_in),
        .sel_ref   (sel_ref),
        .busy      (busy),
        .done      (done),
        .result    (result),
        .overrange (overrange)
    );

    // behavioural integrator and comparator
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (int_rst)      acc <= 0;
        else if (sel_in)  acc <= acc + vin_code;
        else if (sel_ref) acc <= acc - T1;
    end
    assign cmp_pos = (acc > 0);

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // monitor / scoreboard
    int n_rst = 0, n_in = 0, n_ref = 0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (int_rst) n_rst++;
            if (sel_in)  n_in++;
            if (sel_ref) n_ref++;
            if (sel_in && sel_ref) chk(1'b0, "R4 select overlap", 1, 0);
            if (done) begin
                if (sbq.size() == 0) begin
                    chk(1'b0, "R9 unexpected done", 1, 0);
                end else begin
                    exp_t e;
                    e = sbq.pop_front();
                    chk(int'(result) == e.code, "R5/R6/R7 result", int'(result), e.code);
                    chk(overrange == e.ovr, "R6/R7 overrange", int'(overrange), int'(e.ovr));
                    chk((cyc - start_cyc) == e.lat, "R8 done latency", cyc - start_cyc, e.lat);
                    chk(n_rst == RST_CYC, "R2 discharge cycles", n_rst, RST_CYC);
                    chk(n_in == T1, "R3 integrate cycles", n_in, T1);
                    chk(n_ref == e.nref, "R4 deintegrate cycles", n_ref, e.nref);
                    chk(!busy, "R8 busy low in done", int'(busy), 0);
                end
                n_rst = 0; n_in = 0; n_ref = 0;
            end
        end
    end

    // driver
    task automatic run_conv(input int k, input bit poke, input int prev_code);
        exp_t e;
        int d;
        d = (k >= FULL) ? T1 : k + 1;
        e.code = (k > FULL) ? FULL : k;
        e.ovr  = (k > FULL);
        e.lat  = 1 + RST_CYC + T1 + d;
        e.nref = d;
        sbq.push_back(e);
        vin_code = k;
        @(negedge clk);
        start = 1'b1;
        start_cyc = cyc;
        @(negedge clk);
        start = 1'b0;
        chk(busy && int_rst, "R2 busy and discharge next cycle", int'(busy && int_rst), 1);
        repeat (10) @(negedge clk);
        chk(int'(result) == prev_code, "R10 result held during conversion", int'(result), prev_code);
        if (poke) begin
            start = 1'b1;                       // R9: ignored while busy
            @(negedge clk);
            start = 1'b0;
        end
        while (!done) @(negedge clk);
        if (poke) begin
            start = 1'b1;                       // R9: ignored in DONE
        end
        @(negedge clk);
        start = 1'b0;
        chk(!busy && !done, "R8 idle after done", int'(busy || done), 0);
        repeat (4) @(negedge clk);
        chk(!busy && int'(result) == e.code, "R9 R10 no restart, result held",
            int'(result), e.code);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(!int_rst && !sel_in && !sel_ref && !busy && !done && !overrange && result == '0,
            "R1 reset state", int'({int_rst, sel_in, sel_ref, busy, done, overrange}), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(!busy && !done, "R1 idle after reset", int'(busy), 0);
        run_conv(0,    1'b0, 0);
        run_conv(1,    1'b0, 0);
        run_conv(100,  1'b1, 1);
        run_conv(FULL, 1'b0, 100);      // R7 exact full scale
        run_conv(T1,   1'b0, FULL);     // R6 overrange
        run_conv(400,  1'b1, FULL);     // R6 deep overrange with start pokes
        run_conv(37,   1'b0, FULL);
        repeat (3) @(negedge clk);
        chk(sbq.size() == 0, "R8 every conversion completed", sbq.size(), 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule